// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement Control

This block holds the in-flight instructions of an out-of-order core in program order and decides when each one leaves. Every cycle a group of renamed instructions arrives from the front end. Lanes that are valid and not already marked dead are appended at the young end of a circular buffer. The execute stage reports completions by sequence number, and those reports mark the matching entries as ready. From the old end, the controller retires up to a fixed number of entries per cycle, strictly in order. It stops at the first entry that cannot leave.

When execute detects a misprediction, it sends a squash point. The controller then switches into a squash mode for several cycles. In this mode it walks the buffer from the youngest entry backwards, one entry per cycle, and marks each entry dead until it reaches the squash point. A dead entry is later dropped from the old end without any architectural effect.

An instruction that must not run speculatively waits until it reaches the old end. At that point the controller sends its sequence number back to execute as a request to run it, and stalls until the matching completion arrives. All feedback to the earlier stages is registered and appears one cycle after the cycle that produced it. That feedback covers the last retired sequence number, the squash pulses, the redirect data, the free-slot count and the retire count.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset, ctl_mode is 0 (idle), fb_free equals DEPTH, and ret_cnt, fb_done_seq, fb_squash, fb_rob_sqz and fb_ns_vld are all 0.
- R2: In a normal-mode cycle without a squash request, lanes with ins_vld=1 and ins_sqd=0 are appended in lane order, lane 0 oldest. Only as many lanes as there are free slots at the start of the cycle are taken, and the rest are dropped. One cycle later, fb_free shows DEPTH minus the occupancy left after that cycle's inserts and retirements.
- R3: An entry at the old end that is ready and executed retires. At most CM_W entries are examined per cycle. One cycle later, ret_cnt gives the number retired, and fb_done_seq and ret_pc give the sequence number and PC of the youngest entry retired in that cycle.
- R4: Retirement stops at the first examined entry that cannot retire. Younger entries that are already ready stay in the buffer.
- R5: An entry marked dead (squashed) leaves the old end once it is examined. It does not count in ret_cnt and does not change fb_done_seq or ret_pc. It does use one of the CM_W examination slots.
- R6: If the oldest entry is ready, not executed and non-speculative, then one cycle later fb_ns_vld pulses for one cycle with that entry's number on fb_ns_seq. Retirement stops for that cycle and the entry's ready bit is cleared, so no further request follows. The entry retires after a later completion with cp_exe=1.
- R7: A completion report (cp_vld=1) matching a live entry's sequence number sets that entry's ready bit. With cp_exe=1 it also sets the executed bit. Reports are applied in every mode, including squash mode, and first affect retirement in the following cycle.
- R8: A squash request (sq_req=1) outside squash mode does three things one cycle later. It sets ctl_mode to 2 and pulses fb_squash for one cycle with fb_rob_sqz=1. It makes fb_done_seq equal to sq_seq. It copies sq_mispred, sq_taken, sq_next_pc and sq_mis_pc to the fb_ redirect outputs. The renamed group of that cycle is dropped and nothing retires in it.
- R9: In squash mode, each cycle marks the youngest not-yet-walked entry dead. One cycle later, fb_rob_sqz=1 and fb_done_seq holds that entry's number. The walk ends without marking anything when it reaches the entry whose number equals the squash point, or when it has marked every entry. In the cycle it ends, fb_rob_sqz is 0 and ctl_mode returns to 1 (running).
- R10: In squash mode, no entry is inserted or retired, fb_free stays constant, and further squash requests have no effect.
- R11: Outside squash mode, ctl_mode is 0 when the buffer is empty after the cycle's work and 1 otherwise.
- R12: ret_fault pulses one cycle after a cycle in which a retired (not squashed) entry carried its fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | RN_W | Renamed lane valid |
| ins_sqd | input | RN_W | Renamed lane already dead, not inserted |
| ins_ns | input | RN_W | Lane is non-speculative |
| ins_flt | input | RN_W | Lane carries a fault flag |
| ins_seq | input | RN_W x SEQ_W | Lane sequence numbers |
| ins_pc | input | RN_W x PC_W | Lane PCs |
| cp_vld | input | CP_W | Completion report valid |
| cp_exe | input | CP_W | Completion means executed (0: ready only) |
| cp_seq | input | CP_W x SEQ_W | Completed sequence numbers |
| sq_req | input | 1 | Squash request from execute |
| sq_seq | input | SEQ_W | Squash point sequence number |
| sq_mispred | input | 1 | Squash caused by branch mispredict |
| sq_taken | input | 1 | Resolved branch direction |
| sq_next_pc | input | PC_W | Redirect target |
| sq_mis_pc | input | PC_W | PC of the mispredicted branch |
| ctl_mode | output | 2 | 0 idle, 1 running, 2 squashing |
| fb_done_seq | output | SEQ_W | Last retired / squash / walk sequence number |
| fb_squash | output | 1 | One-cycle squash pulse |
| fb_rob_sqz | output | 1 | Buffer squash in progress |
| fb_mispred | output | 1 | Copied mispredict flag |
| fb_taken | output | 1 | Copied taken flag |
| fb_next_pc | output | PC_W | Copied redirect target |
| fb_mis_pc | output | PC_W | Copied branch PC |
| fb_ns_vld | output | 1 | Non-speculative execute request |
| fb_ns_seq | output | SEQ_W | Sequence number of that request |
| fb_free | output | clog2(DEPTH+1) | Free buffer slots |
| ret_cnt | output | clog2(CM_W+1) | Entries retired last cycle |
| ret_fault | output | 1 | A retired entry was faulted |
| ret_pc | output | PC_W | PC of the youngest retired entry |

## Verification
The hardest situation to reach is a completion report that lands on an entry while the walk is in progress, followed by a mixed retirement cycle. In that cycle, one slot commits a live entry and the next slot silently drops a dead one. The bench gets there by filling two entries, squashing to the older one, and sending its completion while the walk is marking the younger one. It also sends a second squash request and a renamed group in the same walk cycle. The retire count of 1 and a done sequence number that falls back to the older entry show that the ready bit survived the squash and that the dead entry left without effect. A second walk with a squash point that is absent from the buffer drives the walk to the old end and beyond its empty-buffer limit.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_RUN  = 2'd1,
    M_SQZ  = 2'd2
  } mode_e;
endpackage

// File: rtl/rob_insert.sv
// Compacts the valid, live lanes of a renamed group into consecutive
// offsets from the tail, limited by the free space.
module rob_insert #(
  parameter int RN_W = 2,
  parameter int AW   = 3,
  parameter int CW   = 4
)(
  input  logic [RN_W-1:0]         vld_i,
  input  logic [RN_W-1:0]         sqd_i,
  input  logic [CW-1:0]           space_i,
  output logic [RN_W-1:0]         take_o,
  output logic [RN_W-1:0][AW-1:0] ofs_o,
  output logic [CW-1:0]           cnt_o
);
  logic [CW-1:0] acc;

  always_comb begin
    acc    = '0;
    take_o = '0;
    ofs_o  = '0;
    for (int i = 0; i < RN_W; i++) begin
      ofs_o[i] = acc[AW-1:0];
      if (vld_i[i] && !sqd_i[i] && (acc < space_i)) begin
        take_o[i] = 1'b1;
        acc       = acc + 1'b1;
      end
    end
    cnt_o = acc;
  end
endmodule

// File: rtl/rob_retire.sv
// Examines up to CM_W entries from the head and decides which leave.
module rob_retire #(
  parameter int DEPTH = 8,
  parameter int CM_W  = 2,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RCW  = $clog2(CM_W + 1)
)(
  input  logic [AW-1:0]    head_i,
  input  logic [CW-1:0]    count_i,
  input  logic [DEPTH-1:0] sq_i,
  input  logic [DEPTH-1:0] rdy_i,
  input  logic [DEPTH-1:0] exe_i,
  input  logic [DEPTH-1:0] ns_i,
  input  logic [DEPTH-1:0] flt_i,
  input  logic [SEQ_W-1:0] seq_i [DEPTH],
  input  logic [PC_W-1:0]  pc_i  [DEPTH],
  output logic [RCW-1:0]   pop_o,
  output logic [RCW-1:0]   cmt_o,
  output logic             any_cmt_o,
  output logic             any_flt_o,
  output logic [SEQ_W-1:0] last_seq_o,
  output logic [PC_W-1:0]  last_pc_o,
  output logic             ns_hit_o,
  output logic [AW-1:0]    ns_idx_o,
  output logic [SEQ_W-1:0] ns_seq_o
);
  logic          go;
  logic [AW-1:0] idx;

  always_comb begin
    go         = 1'b1;
    idx        = head_i;
    pop_o      = '0;
    cmt_o      = '0;
    any_cmt_o  = 1'b0;
    any_flt_o  = 1'b0;
    last_seq_o = '0;
    last_pc_o  = '0;
    ns_hit_o   = 1'b0;
    ns_idx_o   = '0;
    ns_seq_o   = '0;
    for (int k = 0; k < CM_W; k++) begin
      idx = head_i + AW'(k);
      if (go && (k < int'(count_i))) begin
        if (sq_i[idx]) begin
          pop_o = pop_o + 1'b1;
        end else if (rdy_i[idx] && exe_i[idx]) begin
          pop_o      = pop_o + 1'b1;
          cmt_o      = cmt_o + 1'b1;
          any_cmt_o  = 1'b1;
          any_flt_o  = any_flt_o | flt_i[idx];
          last_seq_o = seq_i[idx];
          last_pc_o  = pc_i[idx];
        end else begin
          go = 1'b0;
          if (rdy_i[idx] && ns_i[idx]) begin
            ns_hit_o = 1'b1;
            ns_idx_o = idx;
            ns_seq_o = seq_i[idx];
          end
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_walk.sv
// Squash walker: one entry per cycle from the youngest toward the head.
module rob_walk #(
  parameter int AW    = 3,
  parameter int CW    = 4,
  parameter int SEQ_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [AW-1:0]    tail_i,
  input  logic [CW-1:0]    count_i,
  input  logic [SEQ_W-1:0] point_i,
  input  logic [SEQ_W-1:0] cur_seq_i,
  output logic [AW-1:0]    wk_o,
  output logic             step_o,
  output logic             fin_o
);
  logic [CW-1:0]    left_q;
  logic [SEQ_W-1:0] point_q;
  logic             reached;

  assign reached = (left_q == '0) || (cur_seq_i == point_q);
  assign step_o  = active_i && !reached;
  assign fin_o   = active_i && reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_o    <= '0;
      left_q  <= '0;
      point_q <= '0;
    end else if (start_i) begin
      wk_o    <= tail_i - 1'b1;
      left_q  <= count_i;
      point_q <= point_i;
    end else if (step_o) begin
      wk_o   <= wk_o - 1'b1;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RN_W  = 2,
  parameter int CM_W  = 2,
  parameter int CP_W  = 2,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RCW  = $clog2(CM_W + 1)
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [RN_W-1:0]            ins_vld,
  input  logic [RN_W-1:0]            ins_sqd,
  input  logic [RN_W-1:0]            ins_ns,
  input  logic [RN_W-1:0]            ins_flt,
  input  logic [RN_W-1:0][SEQ_W-1:0] ins_seq,
  input  logic [RN_W-1:0][PC_W-1:0]  ins_pc,
  input  logic [CP_W-1:0]            cp_vld,
  input  logic [CP_W-1:0]            cp_exe,
  input  logic [CP_W-1:0][SEQ_W-1:0] cp_seq,
  input  logic                       sq_req,
  input  logic [SEQ_W-1:0]           sq_seq,
  input  logic                       sq_mispred,
  input  logic                       sq_taken,
  input  logic [PC_W-1:0]            sq_next_pc,
  input  logic [PC_W-1:0]            sq_mis_pc,
  output logic [1:0]                 ctl_mode,
  output logic [SEQ_W-1:0]           fb_done_seq,
  output logic                       fb_squash,
  output logic                       fb_rob_sqz,
  output logic                       fb_mispred,
  output logic                       fb_taken,
  output logic [PC_W-1:0]            fb_next_pc,
  output logic [PC_W-1:0]            fb_mis_pc,
  output logic                       fb_ns_vld,
  output logic [SEQ_W-1:0]           fb_ns_seq,
  output logic [CW-1:0]              fb_free,
  output logic [RCW-1:0]             ret_cnt,
  output logic                       ret_fault,
  output logic [PC_W-1:0]            ret_pc
);
  // ---------------- state ----------------
  mode_e            mode_q, mode_n;
  logic [AW-1:0]    head_q, tail_q;
  logic [CW-1:0]    count_q, count_n;
  logic [DEPTH-1:0] v_q, rdy_q, exe_q, sq_q, ns_q, flt_q;
  logic [DEPTH-1:0] v_n, rdy_n, exe_n, sq_n, ns_n, flt_n;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];

  // ---------------- control ----------------
  logic in_sqz, take_sq, run_work;
  assign in_sqz   = (mode_q == M_SQZ);
  assign take_sq  = !in_sqz && sq_req;
  assign run_work = !in_sqz && !sq_req;

  // ---------------- insertion ----------------
  logic [RN_W-1:0]         take;
  logic [RN_W-1:0][AW-1:0] ofs;
  logic [CW-1:0]           take_cnt, space;
  assign space = CW'(DEPTH) - count_q;

  rob_insert #(.RN_W(RN_W), .AW(AW), .CW(CW)) u_ins (
    .vld_i   (ins_vld),
    .sqd_i   (ins_sqd),
    .space_i (space),
    .take_o  (take),
    .ofs_o   (ofs),
    .cnt_o   (take_cnt)
  );

  // ---------------- retirement ----------------
  logic [RCW-1:0]   pop, cmt;
  logic             any_cmt, any_flt, ns_hit;
  logic [SEQ_W-1:0] last_seq, ns_seq;
  logic [PC_W-1:0]  last_pc;
  logic [AW-1:0]    ns_idx;

  rob_retire #(.DEPTH(DEPTH), .CM_W(CM_W), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_ret (
    .head_i     (head_q),
    .count_i    (count_q),
    .sq_i       (sq_q),
    .rdy_i      (rdy_q),
    .exe_i      (exe_q),
    .ns_i       (ns_q),
    .flt_i      (flt_q),
    .seq_i      (seq_q),
    .pc_i       (pc_q),
    .pop_o      (pop),
    .cmt_o      (cmt),
    .any_cmt_o  (any_cmt),
    .any_flt_o  (any_flt),
    .last_seq_o (last_seq),
    .last_pc_o  (last_pc),
    .ns_hit_o   (ns_hit),
    .ns_idx_o   (ns_idx),
    .ns_seq_o   (ns_seq)
  );

  // ---------------- squash walk ----------------
  logic [AW-1:0] wk;
  logic          step, fin;

  rob_walk #(.AW(AW), .CW(CW), .SEQ_W(SEQ_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (take_sq),
    .active_i  (in_sqz),
    .tail_i    (tail_q),
    .count_i   (count_q),
    .point_i   (sq_seq),
    .cur_seq_i (seq_q[wk]),
    .wk_o      (wk),
    .step_o    (step),
    .fin_o     (fin)
  );

  // ---------------- next state ----------------
  logic [AW-1:0] w_idx;

  always_comb begin
    count_n = count_q;
    if (run_work) count_n = count_q + take_cnt - CW'(pop);
  end

  always_comb begin
    if (take_sq)               mode_n = M_SQZ;
    else if (in_sqz)           mode_n = fin ? M_RUN : M_SQZ;
    else if (count_n == '0)    mode_n = M_IDLE;
    else                       mode_n = M_RUN;
  end

  always_comb begin
    v_n   = v_q;
    rdy_n = rdy_q;
    exe_n = exe_q;
    sq_n  = sq_q;
    ns_n  = ns_q;
    flt_n = flt_q;
    w_idx = '0;
    // non-speculative head parks until execute reports again
    if (run_work && ns_hit) rdy_n[ns_idx] = 1'b0;
    // completion marking, applied in every mode
    for (int p = 0; p < CP_W; p++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (cp_vld[p] && v_q[e] && (seq_q[e] == cp_seq[p])) begin
          rdy_n[e] = 1'b1;
          if (cp_exe[p]) exe_n[e] = 1'b1;
        end
      end
    end
    // release retired or dropped head entries
    for (int k = 0; k < CM_W; k++) begin
      if (run_work && (k < int'(pop))) begin
        w_idx        = head_q + AW'(k);
        v_n[w_idx]   = 1'b0;
      end
    end
    // allocate new entries
    for (int i = 0; i < RN_W; i++) begin
      if (run_work && take[i]) begin
        w_idx        = tail_q + ofs[i];
        v_n[w_idx]   = 1'b1;
        rdy_n[w_idx] = 1'b0;
        exe_n[w_idx] = 1'b0;
        sq_n[w_idx]  = 1'b0;
        ns_n[w_idx]  = ins_ns[i];
        flt_n[w_idx] = ins_flt[i];
      end
    end
    // squash walk marks one entry
    if (step) sq_n[wk] = 1'b1;
  end

  // ---------------- payload arrays (no reset) ----------------
  always_ff @(posedge clk) begin
    for (int i = 0; i < RN_W; i++) begin
      if (run_work && take[i]) begin
        seq_q[tail_q + ofs[i]] <= ins_seq[i];
        pc_q[tail_q + ofs[i]]  <= ins_pc[i];
      end
    end
  end

  // ---------------- control state and registered feedback ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_IDLE;
      head_q      <= '0;
      tail_q      <= '0;
      count_q     <= '0;
      v_q         <= '0;
      rdy_q       <= '0;
      exe_q       <= '0;
      sq_q        <= '0;
      ns_q        <= '0;
      flt_q       <= '0;
      fb_done_seq <= '0;
      fb_squash   <= 1'b0;
      fb_rob_sqz  <= 1'b0;
      fb_mispred  <= 1'b0;
      fb_taken    <= 1'b0;
      fb_next_pc  <= '0;
      fb_mis_pc   <= '0;
      fb_ns_vld   <= 1'b0;
      fb_ns_seq   <= '0;
      fb_free     <= CW'(DEPTH);
      ret_cnt     <= '0;
      ret_fault   <= 1'b0;
      ret_pc      <= '0;
    end else begin
      mode_q  <= mode_n;
      count_q <= count_n;
      v_q     <= v_n;
      rdy_q   <= rdy_n;
      exe_q   <= exe_n;
      sq_q    <= sq_n;
      ns_q    <= ns_n;
      flt_q   <= flt_n;
      if (run_work) begin
        head_q <= head_q + AW'(pop);
        tail_q <= tail_q + AW'(take_cnt);
      end

      fb_squash  <= take_sq;
      fb_rob_sqz <= take_sq | step;
      if (take_sq) begin
        fb_done_seq <= sq_seq;
        fb_mispred  <= sq_mispred;
        fb_taken    <= sq_taken;
        fb_next_pc  <= sq_next_pc;
        fb_mis_pc   <= sq_mis_pc;
      end else if (step) begin
        fb_done_seq <= seq_q[wk];
      end else if (run_work && any_cmt) begin
        fb_done_seq <= last_seq;
      end

      fb_ns_vld <= run_work & ns_hit;
      if (run_work && ns_hit) fb_ns_seq <= ns_seq;

      ret_cnt   <= run_work ? cmt : '0;
      ret_fault <= run_work & any_flt;
      if (run_work && any_cmt) ret_pc <= last_pc;

      fb_free <= CW'(DEPTH) - count_n;
    end
  end

  assign ctl_mode = mode_q;
endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
  parameter int DEPTH = 8,
  parameter int CM_W  = 2,
  parameter int SEQ_W = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RCW  = $clog2(CM_W + 1)
)(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       ctl_mode,
  input logic             fb_squash,
  input logic             fb_rob_sqz,
  input logic [SEQ_W-1:0] fb_done_seq,
  input logic [SEQ_W-1:0] sq_seq,
  input logic [CW-1:0]    fb_free,
  input logic [RCW-1:0]   ret_cnt,
  input logic             fb_ns_vld
);
  a_r2_free_bound: assert property (@(posedge clk) disable iff (rst)
    fb_free <= CW'(DEPTH));

  a_r3_width_cap: assert property (@(posedge clk) disable iff (rst)
    ret_cnt <= RCW'(CM_W));

  a_r8_pulse_in_sqz: assert property (@(posedge clk) disable iff (rst)
    fb_squash |-> (fb_rob_sqz && ctl_mode == 2'd2));

  a_r8_echo_point: assert property (@(posedge clk) disable iff (rst)
    fb_squash |-> (fb_done_seq == $past(sq_seq)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fb_squash |=> !fb_squash);

  a_r10_no_retire: assert property (@(posedge clk) disable iff (rst)
    (ctl_mode == 2'd2) |=> (ret_cnt == '0 && !fb_ns_vld));

  a_r10_free_frozen: assert property (@(posedge clk) disable iff (rst)
    (ctl_mode == 2'd2) |=> $stable(fb_free));
endmodule

bind rob_commit_ctrl rob_commit_chk #(
  .DEPTH (DEPTH),
  .CM_W  (CM_W),
  .SEQ_W (SEQ_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_mode    (ctl_mode),
  .fb_squash   (fb_squash),
  .fb_rob_sqz  (fb_rob_sqz),
  .fb_done_seq (fb_done_seq),
  .sq_seq      (sq_seq),
  .fb_free     (fb_free),
  .ret_cnt     (ret_cnt),
  .fb_ns_vld   (fb_ns_vld)
);

// File: tb/sim_rob_commit_ctrl.sv
`timescale 1ns/1ps
module sim_rob_commit_ctrl;
  localparam int DEPTH = 8, RN_W = 2, CM_W = 2, CP_W = 2, SEQ_W = 8, PC_W = 16;
  localparam int CW = $clog2(DEPTH + 1), RCW = $clog2(CM_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RN_W-1:0] ins_vld, ins_sqd, ins_ns, ins_flt;
  logic [RN_W-1:0][SEQ_W-1:0] ins_seq;
  logic [RN_W-1:0][PC_W-1:0]  ins_pc;
  logic [CP_W-1:0] cp_vld, cp_exe;
  logic [CP_W-1:0][SEQ_W-1:0] cp_seq;
  logic sq_req, sq_mispred, sq_taken;
  logic [SEQ_W-1:0] sq_seq;
  logic [PC_W-1:0] sq_next_pc, sq_mis_pc;
  logic [1:0] ctl_mode;
  logic [SEQ_W-1:0] fb_done_seq, fb_ns_seq;
  logic fb_squash, fb_rob_sqz, fb_mispred, fb_taken, fb_ns_vld, ret_fault;
  logic [PC_W-1:0] fb_next_pc, fb_mis_pc, ret_pc;
  logic [CW-1:0] fb_free;
  logic [RCW-1:0] ret_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rob_commit_ctrl #(.DEPTH(DEPTH), .RN_W(RN_W), .CM_W(CM_W), .CP_W(CP_W),
                    .SEQ_W(SEQ_W), .PC_W(PC_W)) u0 (
    .clk(clk), .rst(rst),
    .ins_vld(ins_vld), .ins_sqd(ins_sqd), .ins_ns(ins_ns), .ins_flt(ins_flt),
    .ins_seq(ins_seq), .ins_pc(ins_pc),
    .cp_vld(cp_vld), .cp_exe(cp_exe), .cp_seq(cp_seq),
    .sq_req(sq_req), .sq_seq(sq_seq), .sq_mispred(sq_mispred), .sq_taken(sq_taken),
    .sq_next_pc(sq_next_pc), .sq_mis_pc(sq_mis_pc),
    .ctl_mode(ctl_mode), .fb_done_seq(fb_done_seq), .fb_squash(fb_squash),
    .fb_rob_sqz(fb_rob_sqz), .fb_mispred(fb_mispred), .fb_taken(fb_taken),
    .fb_next_pc(fb_next_pc), .fb_mis_pc(fb_mis_pc), .fb_ns_vld(fb_ns_vld),
    .fb_ns_seq(fb_ns_seq), .fb_free(fb_free), .ret_cnt(ret_cnt),
    .ret_fault(ret_fault), .ret_pc(ret_pc)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    ins_vld = '0; ins_sqd = '0; ins_ns = '0; ins_flt = '0;
    ins_seq = '0; ins_pc = '0;
    cp_vld = '0; cp_exe = '0; cp_seq = '0;
    sq_req = 1'b0; sq_seq = '0; sq_mispred = 1'b0; sq_taken = 1'b0;
    sq_next_pc = '0; sq_mis_pc = '0;
  endtask

  task automatic put(int l, int s, bit sqd, bit ns, bit flt);
    ins_vld[l] = 1'b1;
    ins_sqd[l] = sqd;
    ins_ns[l]  = ns;
    ins_flt[l] = flt;
    ins_seq[l] = SEQ_W'(s);
    ins_pc[l]  = PC_W'(16'h1000 + s);
  endtask

  task automatic done_rpt(int p, int s, bit exe);
    cp_vld[p] = 1'b1;
    cp_exe[p] = exe;
    cp_seq[p] = SEQ_W'(s);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode", ctl_mode, 0);
    chk("R1 free", fb_free, 8);
    chk("R1 ret_cnt", ret_cnt, 0);
    chk("R1 done_seq", fb_done_seq, 0);
    chk("R1 flags", {fb_squash, fb_rob_sqz, fb_ns_vld}, 0);

    // R2 insertion, skip of dead and invalid lanes
    put(0, 10, 0, 0, 0); put(1, 11, 0, 0, 0); cyc(); clr();
    chk("R2 free after two", fb_free, 6);
    chk("R11 mode running", ctl_mode, 1);
    put(0, 12, 1, 0, 0); put(1, 13, 0, 0, 0); cyc(); clr();
    chk("R2 dead lane skipped", fb_free, 5);
    put(1, 14, 0, 0, 0); cyc(); clr();
    chk("R2 lane1 only", fb_free, 4);

    // R4 younger ready waits behind unready head
    done_rpt(0, 11, 1); cyc(); clr();
    chk("R4 blocked", ret_cnt, 0);
    cyc();
    chk("R4 still blocked", ret_cnt, 0);
    chk("R4 occupancy", fb_free, 4);
    // R7 completion takes effect next cycle, R3 retire
    done_rpt(0, 10, 1); cyc(); clr();
    chk("R7 no same-cycle retire", ret_cnt, 0);
    cyc();
    chk("R3 two retired", ret_cnt, 2);
    chk("R3 done seq", fb_done_seq, 11);
    chk("R3 ret pc", ret_pc, 16'h100B);
    chk("R2 free after retire", fb_free, 6);
    done_rpt(0, 13, 1); done_rpt(1, 14, 1); cyc(); clr();
    cyc();
    chk("R3 drain", ret_cnt, 2);
    chk("R3 done seq 14", fb_done_seq, 14);
    chk("R2 empty free", fb_free, 8);
    chk("R11 mode idle", ctl_mode, 0);

    // R3 width limit with four ready, R12 fault flag
    put(0, 20, 0, 0, 0); put(1, 21, 0, 0, 0); cyc(); clr();
    put(0, 22, 0, 0, 1); put(1, 23, 0, 0, 0); cyc(); clr();
    chk("R2 four in", fb_free, 4);
    done_rpt(0, 22, 1); done_rpt(1, 23, 1); cyc(); clr();
    done_rpt(0, 20, 1); done_rpt(1, 21, 1); cyc(); clr();
    chk("R4 young ready held", ret_cnt, 0);
    cyc();
    chk("R3 width cap", ret_cnt, 2);
    chk("R3 done 21", fb_done_seq, 21);
    chk("R12 no fault", ret_fault, 0);
    cyc();
    chk("R3 second pair", ret_cnt, 2);
    chk("R3 done 23", fb_done_seq, 23);
    chk("R12 fault pulse", ret_fault, 1);
    chk("R2 free 8", fb_free, 8);

    // R6 non-speculative head
    put(0, 30, 0, 1, 0); put(1, 31, 0, 0, 0); cyc(); clr();
    done_rpt(0, 30, 0); done_rpt(1, 31, 1); cyc(); clr();
    chk("R6 no early request", fb_ns_vld, 0);
    cyc();
    chk("R6 request", fb_ns_vld, 1);
    chk("R6 request seq", fb_ns_seq, 30);
    chk("R6 stall", ret_cnt, 0);
    cyc();
    chk("R6 single request", fb_ns_vld, 0);
    chk("R6 still stalled", ret_cnt, 0);
    done_rpt(0, 30, 1); cyc(); clr();
    cyc();
    chk("R6 retires after exec", ret_cnt, 2);
    chk("R6 done 31", fb_done_seq, 31);

    // R8 squash request to the older of two
    put(0, 40, 0, 0, 0); put(1, 41, 0, 0, 0); cyc(); clr();
    sq_req = 1'b1; sq_seq = 8'd40; sq_mispred = 1'b1; sq_taken = 1'b0;
    sq_next_pc = 16'h2222; sq_mis_pc = 16'h3333;
    put(0, 42, 0, 0, 0);
    cyc(); clr();
    chk("R8 mode squash", ctl_mode, 2);
    chk("R8 pulse", {fb_squash, fb_rob_sqz}, 2'b11);
    chk("R8 echo seq", fb_done_seq, 40);
    chk("R8 redirect", {fb_mispred, fb_taken, fb_next_pc, fb_mis_pc}, {2'b10, 16'h2222, 16'h3333});
    chk("R8 group dropped", fb_free, 6);
    // R9 walk step, R10 ignored inputs, R7 completion in squash mode
    sq_req = 1'b1; sq_seq = 8'd99; put(0, 50, 0, 0, 0); done_rpt(0, 40, 1);
    cyc(); clr();
    chk("R9 step flag", fb_rob_sqz, 1);
    chk("R9 step seq", fb_done_seq, 41);
    chk("R10 second request ignored", fb_squash, 0);
    chk("R10 free frozen", fb_free, 6);
    cyc();
    chk("R9 back to running", ctl_mode, 1);
    chk("R9 flag low on finish", fb_rob_sqz, 0);
    cyc();
    chk("R5 silent drop", ret_cnt, 1);
    chk("R5 done not moved", fb_done_seq, 40);
    chk("R7 ready kept", fb_free, 8);

    // R9 walk to the head when point is absent
    put(0, 60, 0, 0, 0); put(1, 61, 0, 0, 0); cyc(); clr();
    put(0, 62, 0, 0, 0); cyc(); clr();
    sq_req = 1'b1; sq_seq = 8'd5; sq_taken = 1'b1; cyc(); clr();
    chk("R8 taken copied", fb_taken, 1);
    cyc(); chk("R9 walk 62", fb_done_seq, 62);
    cyc(); chk("R9 walk 61", fb_done_seq, 61);
    cyc(); chk("R9 walk 60", fb_done_seq, 60);
    chk("R9 still squashing", ctl_mode, 2);
    cyc();
    chk("R9 finish at empty", {ctl_mode, fb_rob_sqz}, {2'd1, 1'b0});
    cyc();
    chk("R5 slots used", fb_free, 7);
    chk("R5 none counted", ret_cnt, 0);
    cyc();
    chk("R5 last drop", fb_free, 8);
    chk("R11 idle again", ctl_mode, 0);

    // R9 squash point is the youngest entry
    put(0, 70, 0, 0, 0); cyc(); clr();
    sq_req = 1'b1; sq_seq = 8'd70; cyc(); clr();
    cyc();
    chk("R9 immediate finish", {ctl_mode, fb_rob_sqz}, {2'd1, 1'b0});
    done_rpt(0, 70, 1); cyc(); clr();
    cyc();
    chk("R9 point not marked", ret_cnt, 1);
    chk("R9 done 70", fb_done_seq, 70);

    // R2 full buffer drops extra lanes
    for (int g = 0; g < 4; g++) begin
      put(0, 80 + 2 * g, 0, 0, 0); put(1, 81 + 2 * g, 0, 0, 0); cyc(); clr();
    end
    chk("R2 full", fb_free, 0);
    put(0, 88, 0, 0, 0); put(1, 89, 0, 0, 0); cyc(); clr();
    chk("R2 overflow dropped", fb_free, 0);
    for (int g = 0; g < 4; g++) begin
      done_rpt(0, 80 + 2 * g, 1); done_rpt(1, 81 + 2 * g, 1); cyc(); clr();
    end
    chk("R3 done 85", fb_done_seq, 85);
    done_rpt(0, 88, 1); cyc(); clr();
    chk("R3 done 87", fb_done_seq, 87);
    chk("R2 no phantom entry", fb_free, 8);
    cyc();
    chk("R2 nothing left", ret_cnt, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule